// File: doc/BRIEF.md
# Quad I/O Continuous Read Slave

This block is the memory-side engine of a serial flash that answers the quad input/output read command. It watches chip-select, a serial clock and four data lines. All three are brought into the system clock domain and oversampled. Every falling edge of the serial clock shifts in new bits and moves the output forward one step. A frame opens with the command byte 0xEB, sent one bit per clock on line 0. After it come a 24-bit address, a mode byte and sixteen dummy bits, four bits per clock. Data bytes then stream out one nibble per clock, starting at the addressed location and moving to successive locations.

The mode byte decides how the next frame starts. If its upper nibble is 0xA when chip-select rises, the block stays in continuous mode. The next frame then leaves out the command byte and begins directly with the quad address, so random reads cost fewer clocks. Any other mode value sends the block back to waiting for a single-line command byte.

The backing store is an internal byte memory that resets to 0xFF. It is filled through a valid/ready load stream that only accepts words while chip-select is high. A busy input makes every byte fetched during a write cycle read as zero.

Top module: `qrd_slave`

## Requirements
- R1: The command byte is taken MSB first from dq_in[0] over the first 8 falling edges of a non-continuous frame. Only 0xEB starts a read. Any other value keeps the data lines released for the rest of that frame and leaves continuous mode off.
- R2: In a frame that began with 0xEB, each later falling edge takes one nibble, high nibble first. Nibbles 1 to 6 are the address (bits 23..0), nibbles 7 and 8 are the mode byte, and nibbles 9 to 12 are dummy. The high nibble of the first data byte is driven right after falling edge 20.
- R3: Data bytes come from successive addresses. Each byte takes two falling edges, bits 7..4 first and then bits 3..0, driven on dq_out[3:0].
- R4: Only the low log2(MEM_BYTES) address bits select the byte, so reads past the last byte wrap to byte 0.
- R5: If the last mode byte's upper nibble is 0xA when chip-select rises, the next frame starts with the quad address (6 nibbles), then the mode byte (2 nibbles) and 4 dummy nibbles. Data is driven right after falling edge 12.
- R6: If the upper nibble is not 0xA at that point, the next frame is read as a single-line command again.
- R7: A byte fetched while busy is high is output as 0x00.
- R8: dq_oe is 4'hF only while a data byte is being driven and chip-select is low. Otherwise dq_oe is 4'h0 and dq_out is 4'h0.
- R9: Every memory byte reads 0xFF after reset.
- R10: ld_ready follows chip-select (after synchronisation) and is low during a frame. A load word is written on a cycle with both ld_valid and ld_ready high. A held load completes once the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock, idles high, shifts on falling edges |
| dq_in | input | 4 | Data lines as seen at the pads |
| dq_out | output | 4 | Data driven onto the lines |
| dq_oe | output | 4 | Per-line output enable |
| busy | input | 1 | Write in progress; fetched bytes read as zero |
| ld_valid | input | 1 | Load word valid |
| ld_ready | output | 1 | Load word accepted (only outside frames) |
| ld_addr | input | 12 | Load byte address (log2 of MEM_BYTES) |
| ld_data | input | 8 | Load byte value |

## Verification
The load stream and the serial read both use the one memory, and a load can be requested while a frame is fetching bytes. The bench raises ld_valid in the middle of a continuous frame that reads the very address being loaded. It checks that ld_ready stays low and that the frame returns the old byte. After chip-select rises, it confirms that the held word lands and that the next frame reads the new value. A second overlap sets busy high across a continuous frame and expects zero nibbles with the enables still asserted.

// File: rtl/qrd_pkg.sv
package qrd_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_HDR, PH_DATA, PH_SKIP} phase_e;

  localparam logic [7:0] OPC_QIO   = 8'hEB;
  localparam logic [3:0] CONT_KEY  = 4'hA;
  localparam int         CMD_BITS  = 8;
  localparam int         ADR_BITS  = 24;
  localparam int         MODE_BITS = 8;
  localparam int         DUM_BITS  = 16;

  // bit-count marks for a frame that carried the command byte
  localparam logic [5:0] F_ADDR = 6'(CMD_BITS + ADR_BITS);
  localparam logic [5:0] F_MODE = 6'(CMD_BITS + ADR_BITS + MODE_BITS + DUM_BITS);
  localparam logic [5:0] F_DATA = F_MODE;
  // bit-count marks for a continuous frame
  localparam logic [5:0] C_ADDR = 6'(ADR_BITS);
  localparam logic [5:0] C_MODE = 6'(ADR_BITS + MODE_BITS);
  localparam logic [5:0] C_DATA = 6'(ADR_BITS + MODE_BITS + DUM_BITS);
endpackage

// File: rtl/qrd_sync.sv
module qrd_sync #(
  parameter int          W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST;
      q  <= RST;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/qrd_mem.sv
module qrd_mem #(
  parameter int BYTES = 4096,
  localparam int AW   = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] arr [BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) arr[i] <= 8'hFF;
    end else if (we) begin
      arr[waddr] <= wdata;
    end
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/qrd_frame.sv
module qrd_frame
  import qrd_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csn_s,
  input  logic          sck_s,
  input  logic [3:0]    din_s,
  input  logic          busy,
  input  logic [7:0]    rdata,
  output logic [AW-1:0] raddr,
  output logic [3:0]    dq_out,
  output logic [3:0]    dq_oe,
  output logic          byte_ld
);
  phase_e        phase;
  logic [5:0]    cnt, cnt_n;
  logic [23:0]   sh, sh_n;
  logic [7:0]    mode_q, obyte, fetch;
  logic [AW-1:0] ptr;
  logic          half, first, cont, cont_n;
  logic          sck_q, csn_q, fall, rise;
  logic          at_addr, at_mode, at_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b1;
      csn_q <= 1'b1;
    end else begin
      sck_q <= sck_s;
      csn_q <= csn_s;
    end
  end

  assign fall    = sck_q & ~sck_s & ~csn_s;
  assign rise    = csn_s & ~csn_q;
  assign cnt_n   = (phase == PH_CMD) ? cnt + 6'd1 : cnt + 6'd4;
  assign sh_n    = (phase == PH_CMD) ? {sh[22:0], din_s[0]} : {sh[19:0], din_s};
  assign at_addr = cnt_n == (first ? F_ADDR : C_ADDR);
  assign at_mode = cnt_n == (first ? F_MODE : C_MODE);
  assign at_data = cnt_n == (first ? F_DATA : C_DATA);
  assign cont_n  = rise ? ((phase == PH_HDR || phase == PH_DATA) && mode_q[7:4] == CONT_KEY)
                        : cont;
  assign fetch   = busy ? 8'h00 : rdata;
  assign byte_ld = fall & (((phase == PH_HDR) & at_data) | ((phase == PH_DATA) & half));
  assign raddr   = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_CMD;
      cnt    <= '0;
      sh     <= '0;
      mode_q <= '0;
      obyte  <= '0;
      ptr    <= '0;
      half   <= 1'b0;
      first  <= 1'b0;
      cont   <= 1'b0;
    end else if (csn_s) begin
      cont  <= cont_n;
      phase <= cont_n ? PH_HDR : PH_CMD;
      cnt   <= '0;
      sh    <= '0;
      half  <= 1'b0;
      first <= 1'b0;
    end else if (fall) begin
      unique case (phase)
        PH_CMD: begin
          sh  <= sh_n;
          cnt <= cnt_n;
          if (cnt_n == 6'(CMD_BITS)) begin
            if (sh_n[7:0] == OPC_QIO) begin
              phase <= PH_HDR;
              first <= 1'b1;
            end else begin
              phase <= PH_SKIP;
            end
          end
        end
        PH_HDR: begin
          sh  <= sh_n;
          cnt <= cnt_n;
          if (at_addr) ptr <= sh_n[AW-1:0];
          if (at_mode) mode_q <= first ? sh_n[23:16] : sh_n[7:0];
          if (at_data) begin
            phase <= PH_DATA;
            obyte <= fetch;
            ptr   <= ptr + 1'b1;
            half  <= 1'b0;
          end
        end
        PH_DATA: begin
          if (!half) begin
            half <= 1'b1;
          end else begin
            half  <= 1'b0;
            obyte <= fetch;
            ptr   <= ptr + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    dq_oe  = 4'h0;
    dq_out = 4'h0;
    if (phase == PH_DATA && !csn_s) begin
      dq_oe  = 4'hF;
      dq_out = half ? obyte[3:0] : obyte[7:4];
    end
  end
endmodule

// File: rtl/qrd_slave.sv
module qrd_slave #(
  parameter int MEM_BYTES = 4096,
  localparam int AW       = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csn,
  input  logic          sck,
  input  logic [3:0]    dq_in,
  output logic [3:0]    dq_out,
  output logic [3:0]    dq_oe,
  input  logic          busy,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data
);
  logic          csn_s, sck_s;
  logic [3:0]    din_s;
  logic [AW-1:0] mem_raddr;
  logic [7:0]    mem_rdata;
  logic          byte_ld;

  qrd_sync #(.W(6), .RST(6'b110000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({csn, sck, dq_in}),
    .q({csn_s, sck_s, din_s})
  );

  assign ld_ready = csn_s;

  qrd_mem #(.BYTES(MEM_BYTES)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we(ld_valid & ld_ready), .waddr(ld_addr), .wdata(ld_data),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  qrd_frame #(.AW(AW)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .csn_s(csn_s), .sck_s(sck_s), .din_s(din_s),
    .busy(busy), .rdata(mem_rdata), .raddr(mem_raddr),
    .dq_out(dq_out), .dq_oe(dq_oe), .byte_ld(byte_ld)
  );
endmodule

// File: rtl/qrd_chk.sv
module qrd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csn,
  input logic       busy,
  input logic [3:0] dq_oe,
  input logic [3:0] dq_out,
  input logic       ld_ready,
  input logic       byte_ld,
  input logic [7:0] rdata
);
  // R8: enables move together, and released lines carry zero
  assert_oe_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == 4'h0) || (dq_oe == 4'hF));
  assert_out_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == 4'h0) |-> (dq_out == 4'h0));
  // R8: a long-deselected slave never drives
  assert_oe_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (csn && $past(csn) && $past(csn, 2) && $past(csn, 3)) |-> (dq_oe == 4'h0));
  // R10: no load acceptance deep inside a frame
  assert_no_load_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn && $past(!csn) && $past(!csn, 2) && $past(!csn, 3)) |-> !ld_ready);
  // R3 and R7: a fetched byte appears high nibble first, zeroed while busy
  assert_fetch_nibble_R3_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ld |=> ((dq_oe == 4'h0) ||
                 (dq_out == ($past(busy) ? 4'h0 : $past(rdata[7:4])))));
endmodule

bind qrd_slave qrd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csn(csn), .busy(busy),
  .dq_oe(dq_oe), .dq_out(dq_out), .ld_ready(ld_ready),
  .byte_ld(byte_ld), .rdata(mem_rdata)
);

// File: tb/tb_qrd_slave.sv
module tb_qrd_slave;
  localparam int MEMB = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csn = 1'b1;
  logic        sck = 1'b1;
  logic [3:0]  dq_in = 4'h0;
  logic [3:0]  dq_out, dq_oe;
  logic        busy = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [11:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;

  logic [7:0]  em [MEMB];
  logic [3:0]  q_out, q_oe;
  int          checks = 0;
  int          fails = 0;

  always #10 clk = ~clk;

  qrd_slave #(.MEM_BYTES(MEMB)) dut (
    .clk(clk), .rst_n(rst_n), .csn(csn), .sck(sck), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37) ^ (a >> 5) ^ 8'h5C);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] din);
    dq_in = din;
    repeat (3) @(negedge clk);
    sck = 1'b0;
    repeat (6) @(negedge clk);
    q_out = dq_out;
    q_oe  = dq_oe;
    sck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // one frame: optional command byte, quad address, mode, dummy, then data
  task automatic frame(input bit with_op, input logic [7:0] op, input logic [23:0] adr,
                       input logic [7:0] md, input int nbytes, input bit want_data,
                       input bit poke, input string tag);
    int hdr, start, total, bad;
    logic [3:0] din;
    hdr = with_op ? 8 : 0;
    start = with_op ? 19 : 11;
    total = start + 2 * nbytes;
    bad = 0;
    csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < total; k++) begin
      int j;
      j = k - hdr;
      if (with_op && k < 8) din = {3'b000, op[7-k]};
      else if (j < 6) din = adr[23-4*j -: 4];
      else if (j == 6) din = md[7:4];
      else if (j == 7) din = md[3:0];
      else din = 4'h0;
      if (poke && k == 2) begin
        ld_valid = 1'b1;
        ld_addr = 12'h100;
        ld_data = 8'h5A;
      end
      cyc(din);
      if (poke && k == 4) chk(ld_ready == 1'b0, {tag, " R10 ready low in frame"}, ld_ready, 0);
      if (want_data && k >= start) begin
        int d, a;
        logic [7:0] e;
        d = k - start;
        a = (int'(adr) + d / 2) % MEMB;
        e = busy ? 8'h00 : em[a];
        chk(q_oe == 4'hF && q_out == ((d % 2) ? e[3:0] : e[7:4]),
            {tag, " R3 data nibble"}, {q_oe, q_out}, {4'hF, ((d % 2) ? e[3:0] : e[7:4])});
      end else if (q_oe != 4'h0) begin
        bad++;
      end
    end
    chk(bad == 0, {tag, " R8 lines released outside data"}, bad, 0);
    csn = 1'b1;
    repeat (6) @(negedge clk);
    if (poke) begin
      while (!ld_ready) @(negedge clk);
      @(negedge clk);
      ld_valid = 1'b0;
      em[12'h100] = 8'h5A;
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMB; i++) em[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dq_oe == 4'h0, "R8 reset enables", dq_oe, 0);
    chk(ld_ready == 1'b1, "R10 reset ready", ld_ready, 1);

    // R9: erased contents before any load, then R6 with no continuous mode
    frame(1, 8'hEB, 24'h000010, 8'h00, 4, 1, 0, "R9 R2 erased");
    frame(0, 8'h00, 24'h000000, 8'h00, 2, 0, 0, "R6 no opcode skip");

    // R10: fill every byte through the load stream
    for (int a = 0; a < MEMB; a++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_addr = 12'(a);
      ld_data = pat(a);
      em[a] = pat(a);
    end
    @(negedge clk);
    ld_valid = 1'b0;
    chk(ld_ready == 1'b1, "R10 ready idle", ld_ready, 1);

    frame(1, 8'hEB, 24'h000123, 8'hA5, 3, 1, 0, "R2 first frame");
    frame(0, 8'h00, 24'h000800, 8'hA0, 4, 1, 0, "R5 continuous");
    frame(0, 8'h00, 24'h000FFE, 8'h3C, 4, 1, 0, "R4 R5 wrap continuous");
    frame(0, 8'h00, 24'h000000, 8'h00, 2, 0, 0, "R6 left continuous");
    frame(1, 8'h0B, 24'h000000, 8'hA0, 2, 0, 0, "R1 wrong opcode");
    frame(0, 8'h00, 24'h000000, 8'hA0, 2, 0, 0, "R1 still not continuous");
    frame(1, 8'hEB, 24'hABCFFD, 8'hA0, 5, 1, 0, "R4 high address bits");
    busy = 1'b1;
    frame(0, 8'h00, 24'h000200, 8'hAF, 3, 1, 0, "R7 busy zeros");
    busy = 1'b0;
    frame(0, 8'h00, 24'h0000FF, 8'hA0, 3, 1, 1, "R10 load during frame");
    chk(em[12'h100] == 8'h5A, "R10 model", em[12'h100], 8'h5A);
    frame(0, 8'h00, 24'h0000FF, 8'hA0, 3, 1, 0, "R10 load landed");
    frame(0, 8'h00, 24'h000F80, 8'h00, MEMB, 1, 0, "R3 R4 full sweep");
    frame(0, 8'h00, 24'h000000, 8'h00, 2, 0, 0, "R6 after sweep");
    chk(dq_oe == 4'h0, "R8 final enables", dq_oe, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule